// File: doc/BRIEF.md
# Acquisition Event Frame Builder

This block turns the pieces of one acquisition event into a finished, self-describing frame of 32-bit words. The frame is ready to be written into host memory by a separate transfer engine. The producer streams one event as a sequence of payload beats. Each beat carries a bank name and a bank type, plus markers for the start of a bank, the end of a bank and the end of the event. The event ID, trigger mask, timestamp and alignment mode are presented with the first beat. The block stores the payload and a small per-bank descriptor table while it adds up the size fields.

Once the last beat of the event has been accepted, the block emits the frame. The frame starts with a four-word event header and a two-word global bank header. Then, for each bank, it sends a three-word bank header, the payload and any alignment padding. A zero tail rounds the whole frame up to a 32-byte boundary. Two padding rules are selectable:

- The legacy rule pads only the payload to 8 bytes.
- The corrected rule pads the header and payload together to 8 bytes.

The flags word records which rule was used. An event that does not fit the payload buffer or the descriptor table is discarded, and the block raises an error pulse.

Top module: `frame_builder`

## Requirements
- R1: The frame opens with four words in this order: {trigger mask[15:0], event ID[15:0]}, the serial number, the timestamp, and the event size in bytes. The event size counts everything after these four words, up to the end of the last bank, and leaves out the tail padding.
- R2: Word 5 holds the byte total of all bank records, where each record is a bank header plus its payload plus its padding. Word 6 is the flags word: 0x11 under the legacy rule and 0x31 under the corrected rule.
- R3: Each bank is emitted as three header words followed by its payload words in arrival order. The header words are the 32-bit name, the 32-bit type, and the payload length in bytes (4 per word, padding excluded).
- R4: Under the legacy rule (mode input 0), a bank with an odd payload word count is followed by exactly one zero word, and a bank with an even count gets no padding.
- R5: Under the corrected rule (mode input 1), a bank with an even payload word count is followed by exactly one zero word, and a bank with an odd count gets no padding. Every bank record is therefore a multiple of 8 bytes.
- R6: After the last bank, zero words are appended until the total frame length is a multiple of TAIL_WORDS words (8 words = 32 bytes by default).
- R7: The serial number is 0 for the first emitted event after reset and rises by one for each emitted event. A discarded event does not use up a number.
- R8: An event is discarded if it carries more than BUF_DEPTH payload words in total, or more than MAX_BANKS banks. A discarded event produces no output words and raises errOverflow for exactly one cycle, and the next event is framed normally.
- R9: While a frame is being emitted, outData is held stable whenever outValid is high and outReady is low. With outReady held high, the words leave on consecutive cycles with no gaps, and inReady stays low.
- R10: The alignment mode and the event fields are taken from the first beat of the event. Changes on those inputs during later beats have no effect on that event.
- R11: After reset, outValid and errOverflow are low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeAligned | input | 1 | 0 selects the legacy padding rule, 1 the corrected rule; sampled on the first beat |
| evId | input | 16 | Event ID, sampled on the first beat |
| evMask | input | 16 | Trigger mask, sampled on the first beat |
| evTime | input | 32 | Timestamp, sampled on the first beat |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Block accepts input beats (high while collecting) |
| inData | input | 32 | Payload word |
| inBankName | input | 32 | Four-character bank name, taken on the bank's first beat |
| inBankType | input | 32 | Bank type code, taken on the bank's first beat |
| inBankStart | input | 1 | Beat is the first payload word of a bank |
| inBankEnd | input | 1 | Beat is the last payload word of a bank |
| inEventEnd | input | 1 | Beat is the last of the event (set together with inBankEnd) |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Consumer accepts the output word |
| outData | output | 32 | Frame word |
| errOverflow | output | 1 | One-cycle pulse when an event is discarded |

## Verification
A wrong size accumulator or wrong padding decision shows up in the very first frame that uses it. The size words in the header disagree with the number of words that actually follow, and the zero words appear in the wrong places. A bank-index or FIFO-pointer fault makes the payload and the bank headers drift against each other, or leaves words stranded that then surface in the next frame. Any serial-number fault is visible in word 2 of the next emitted event. A stale overflow state shows up as one lost or one spurious frame, followed at once by a missing or an extra errOverflow pulse.

// File: rtl/frame_pkg.sv
package frame_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EVH,
    SEL_GBH,
    SEL_BKH,
    SEL_DATA,
    SEL_ZERO
  } wsel_t;

  // strobes from control to datapath
  typedef struct packed {
    wsel_t      sel;
    logic [2:0] idx;
    logic       pop;
    logic       bankAdv;
    logic       finish;
    logic       drop;
  } ctl_strobe_t;

  localparam logic [31:0] FLAGS_LEGACY  = 32'h0000_0011;
  localparam logic [31:0] FLAGS_ALIGNED = 32'h0000_0031;
  localparam logic [31:0] BANK_HDR_BYTES = 32'd12;

endpackage

// File: rtl/frame_dp.sv
module frame_dp
  import frame_pkg::*;
#(
  parameter int BUF_DEPTH  = 64,
  parameter int MAX_BANKS  = 8,
  parameter int TAIL_WORDS = 8,
  localparam int LW = $clog2(BUF_DEPTH + 1),
  localparam int TW = $clog2(TAIL_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeAligned,
  input  logic [15:0]       evId,
  input  logic [15:0]       evMask,
  input  logic [31:0]       evTime,
  input  logic              inFire,
  input  logic [31:0]       inData,
  input  logic [31:0]       inBankName,
  input  logic [31:0]       inBankType,
  input  logic              inBankStart,
  input  logic              inBankEnd,
  input  ctl_strobe_t       st,
  output logic [31:0]       outData,
  output logic              ovfNow,
  output logic [LW-1:0]     emitLen,
  output logic              emitPad,
  output logic              lastBank,
  output logic [TW-1:0]     tailPad,
  output logic              errOverflow
);

  localparam int AW = $clog2(BUF_DEPTH);
  localparam int BW = $clog2(MAX_BANKS + 1);

  // ---------------- payload FIFO ----------------
  logic [31:0]   fifoMem [BUF_DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [LW-1:0] fifoCount;
  logic          fifoFull;
  logic          push;

  assign fifoFull = (fifoCount == LW'(BUF_DEPTH));
  assign push     = inFire && !fifoFull;

  always_ff @(posedge clk) begin
    if (push) fifoMem[wrPtr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.drop) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (push)   wrPtr <= wrPtr + 1'b1;
      if (st.pop) rdPtr <= rdPtr + 1'b1;
      if (push && !st.pop)      fifoCount <= fifoCount + 1'b1;
      else if (!push && st.pop) fifoCount <= fifoCount - 1'b1;
    end
  end

  // ---------------- collection state ----------------
  logic          firstBeat;
  logic          modeR;
  logic [15:0]   evIdR, evMaskR;
  logic [31:0]   evTimeR;
  logic [BW-1:0] bankCnt;
  logic [LW-1:0] runLen;
  logic [31:0]   allBytes;
  logic          ovfR;
  logic [31:0]   serial;
  logic [BW-1:0] emitBank;

  logic [31:0]   nameT [MAX_BANKS];
  logic [31:0]   typeT [MAX_BANKS];
  logic [LW-1:0] lenT  [MAX_BANKS];

  logic          modeEff;
  logic          tblFull;
  logic [LW-1:0] thisLen;
  logic          thisPad;
  logic [LW-1:0] thisPadded;
  logic [31:0]   thisBytes;

  assign modeEff    = firstBeat ? modeAligned : modeR;
  assign tblFull    = (bankCnt == BW'(MAX_BANKS));
  assign thisLen    = inBankStart ? LW'(1) : runLen + 1'b1;
  assign thisPad    = modeEff ? ~thisLen[0] : thisLen[0];
  assign thisPadded = thisLen + LW'(thisPad);
  assign thisBytes  = BANK_HDR_BYTES + 32'({thisPadded, 2'b00});
  assign ovfNow     = ovfR || (inFire && (fifoFull || tblFull));

  always_ff @(posedge clk) begin
    if (inFire && !tblFull) begin
      if (inBankStart) begin
        nameT[bankCnt[$clog2(MAX_BANKS)-1:0]] <= inBankName;
        typeT[bankCnt[$clog2(MAX_BANKS)-1:0]] <= inBankType;
      end
      if (inBankEnd) lenT[bankCnt[$clog2(MAX_BANKS)-1:0]] <= thisLen;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.drop || st.finish) begin
      firstBeat <= 1'b1;
      bankCnt   <= '0;
      runLen    <= '0;
      allBytes  <= '0;
      ovfR      <= 1'b0;
      emitBank  <= '0;
      if (!rstN) begin
        modeR   <= 1'b0;
        evIdR   <= '0;
        evMaskR <= '0;
        evTimeR <= '0;
      end
    end else begin
      if (inFire) begin
        if (firstBeat) begin
          modeR   <= modeAligned;
          evIdR   <= evId;
          evMaskR <= evMask;
          evTimeR <= evTime;
        end
        firstBeat <= 1'b0;
        runLen    <= thisLen;
        if (fifoFull || tblFull) ovfR <= 1'b1;
        if (inBankEnd && !tblFull) begin
          bankCnt  <= bankCnt + 1'b1;
          allBytes <= allBytes + thisBytes;
        end
      end
      if (st.bankAdv) emitBank <= emitBank + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serial      <= '0;
      errOverflow <= 1'b0;
    end else begin
      errOverflow <= st.drop;
      if (st.finish) serial <= serial + 1'b1;
    end
  end

  // ---------------- emission side ----------------
  logic [31:0] eventBytes;
  logic [31:0] totalWords;
  logic [31:0] flagsWord;
  logic [$clog2(MAX_BANKS)-1:0] eIdx;

  assign eIdx       = emitBank[$clog2(MAX_BANKS)-1:0];
  assign emitLen    = lenT[eIdx];
  assign emitPad    = modeR ? ~emitLen[0] : emitLen[0];
  assign lastBank   = (emitBank == bankCnt - 1'b1);
  assign eventBytes = allBytes + 32'd8;
  assign totalWords = (allBytes >> 2) + 32'd6;
  assign tailPad    = TW'(32'd0 - totalWords);
  assign flagsWord  = modeR ? FLAGS_ALIGNED : FLAGS_LEGACY;

  always_comb begin
    outData = '0;
    unique case (st.sel)
      SEL_EVH: begin
        unique case (st.idx)
          3'd0:    outData = {evMaskR, evIdR};
          3'd1:    outData = serial;
          3'd2:    outData = evTimeR;
          default: outData = eventBytes;
        endcase
      end
      SEL_GBH:  outData = (st.idx == 3'd0) ? allBytes : flagsWord;
      SEL_BKH: begin
        unique case (st.idx)
          3'd0:    outData = nameT[eIdx];
          3'd1:    outData = typeT[eIdx];
          default: outData = 32'({emitLen, 2'b00});
        endcase
      end
      SEL_DATA: outData = fifoMem[rdPtr];
      default:  outData = '0;
    endcase
  end

  // ---------------- assertions ----------------
  a_r3_pop_has_data: assert property (@(posedge clk) disable iff (!rstN)
    st.pop |-> fifoCount != '0);

  a_r7_serial_step: assert property (@(posedge clk) disable iff (!rstN)
    st.finish |=> serial == $past(serial) + 32'd1);

  a_r6_finish_drained: assert property (@(posedge clk) disable iff (!rstN)
    st.finish |=> fifoCount == '0);

  a_r8_drop_clears: assert property (@(posedge clk) disable iff (!rstN)
    st.drop |=> (fifoCount == '0 && bankCnt == '0));

endmodule

// File: rtl/frame_ctl.sv
module frame_ctl
  import frame_pkg::*;
#(
  parameter int BUF_DEPTH  = 64,
  parameter int TAIL_WORDS = 8,
  localparam int LW = $clog2(BUF_DEPTH + 1),
  localparam int TW = $clog2(TAIL_WORDS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inEventEnd,
  input  logic          outReady,
  input  logic          ovfNow,
  input  logic [LW-1:0] emitLen,
  input  logic          emitPad,
  input  logic          lastBank,
  input  logic [TW-1:0] tailPad,
  output logic          inReady,
  output logic          inFire,
  output logic          outValid,
  output ctl_strobe_t   st
);

  typedef enum logic [2:0] {
    S_COLLECT, S_EVH, S_GBH, S_BKH, S_DATA, S_BPAD, S_TAIL
  } state_t;

  state_t        state, nState;
  logic [LW-1:0] cnt, nCnt;
  logic          bankDone;

  assign inReady  = (state == S_COLLECT);
  assign inFire   = inValid && inReady;
  assign outValid = (state != S_COLLECT);

  always_comb begin
    nState   = state;
    nCnt     = cnt;
    st       = '0;
    bankDone = 1'b0;
    unique case (state)
      S_COLLECT: begin
        if (inFire && inEventEnd) begin
          if (ovfNow) st.drop = 1'b1;
          else begin
            nState = S_EVH;
            nCnt   = '0;
          end
        end
      end
      S_EVH: begin
        st.sel = SEL_EVH;
        if (outReady) begin
          if (cnt == LW'(3)) begin nState = S_GBH; nCnt = '0; end
          else nCnt = cnt + 1'b1;
        end
      end
      S_GBH: begin
        st.sel = SEL_GBH;
        if (outReady) begin
          if (cnt == LW'(1)) begin nState = S_BKH; nCnt = '0; end
          else nCnt = cnt + 1'b1;
        end
      end
      S_BKH: begin
        st.sel = SEL_BKH;
        if (outReady) begin
          if (cnt == LW'(2)) begin nState = S_DATA; nCnt = '0; end
          else nCnt = cnt + 1'b1;
        end
      end
      S_DATA: begin
        st.sel = SEL_DATA;
        if (outReady) begin
          st.pop = 1'b1;
          if ((cnt + 1'b1) == emitLen) begin
            if (emitPad) begin nState = S_BPAD; nCnt = '0; end
            else bankDone = 1'b1;
          end else nCnt = cnt + 1'b1;
        end
      end
      S_BPAD: begin
        st.sel = SEL_ZERO;
        if (outReady) bankDone = 1'b1;
      end
      S_TAIL: begin
        st.sel = SEL_ZERO;
        if (outReady) begin
          if ((cnt + 1'b1) == LW'(tailPad)) begin
            st.finish = 1'b1;
            nState    = S_COLLECT;
          end else nCnt = cnt + 1'b1;
        end
      end
      default: nState = S_COLLECT;
    endcase

    if (bankDone) begin
      nCnt = '0;
      if (!lastBank) begin
        st.bankAdv = 1'b1;
        nState     = S_BKH;
      end else if (tailPad != '0) begin
        nState = S_TAIL;
      end else begin
        st.finish = 1'b1;
        nState    = S_COLLECT;
      end
    end
    st.idx = cnt[2:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_COLLECT;
      cnt   <= '0;
    end else begin
      state <= nState;
      cnt   <= nCnt;
    end
  end

  // a bank pad is a single word
  a_r4_pad_one_word: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BPAD && outReady) |=> state != S_BPAD);

  // tail never exceeds the boundary
  a_r6_tail_bound: assert property (@(posedge clk) disable iff (!rstN)
    state == S_TAIL |-> cnt < LW'(TAIL_WORDS));

endmodule

// File: rtl/frame_builder.sv
module frame_builder
  import frame_pkg::*;
#(
  parameter int BUF_DEPTH  = 64,
  parameter int MAX_BANKS  = 8,
  parameter int TAIL_WORDS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeAligned,
  input  logic [15:0] evId,
  input  logic [15:0] evMask,
  input  logic [31:0] evTime,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] inData,
  input  logic [31:0] inBankName,
  input  logic [31:0] inBankType,
  input  logic        inBankStart,
  input  logic        inBankEnd,
  input  logic        inEventEnd,
  output logic        outValid,
  input  logic        outReady,
  output logic [31:0] outData,
  output logic        errOverflow
);

  localparam int LW = $clog2(BUF_DEPTH + 1);
  localparam int TW = $clog2(TAIL_WORDS);

  ctl_strobe_t   st;
  logic          inFire;
  logic          ovfNow;
  logic [LW-1:0] emitLen;
  logic          emitPad;
  logic          lastBank;
  logic [TW-1:0] tailPad;

  frame_ctl #(.BUF_DEPTH(BUF_DEPTH), .TAIL_WORDS(TAIL_WORDS)) u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inEventEnd(inEventEnd),
    .outReady(outReady), .ovfNow(ovfNow), .emitLen(emitLen),
    .emitPad(emitPad), .lastBank(lastBank), .tailPad(tailPad),
    .inReady(inReady), .inFire(inFire), .outValid(outValid), .st(st)
  );

  frame_dp #(.BUF_DEPTH(BUF_DEPTH), .MAX_BANKS(MAX_BANKS), .TAIL_WORDS(TAIL_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .modeAligned(modeAligned), .evId(evId),
    .evMask(evMask), .evTime(evTime), .inFire(inFire), .inData(inData),
    .inBankName(inBankName), .inBankType(inBankType),
    .inBankStart(inBankStart), .inBankEnd(inBankEnd), .st(st),
    .outData(outData), .ovfNow(ovfNow), .emitLen(emitLen),
    .emitPad(emitPad), .lastBank(lastBank), .tailPad(tailPad),
    .errOverflow(errOverflow)
  );

  a_r9_hold_word: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    errOverflow |-> !outValid);

endmodule

// File: tb/test_frame_builder.sv
module test_frame_builder;

  logic        clk = 1'b0;
  logic        rstN;
  logic        modeAligned;
  logic [15:0] evId, evMask;
  logic [31:0] evTime;
  logic        inValid;
  logic        inReady;
  logic [31:0] inData, inBankName, inBankType;
  logic        inBankStart, inBankEnd, inEventEnd;
  logic        outValid;
  logic        outReady;
  logic [31:0] outData;
  logic        errOverflow;

  always #10 clk = ~clk;

  frame_builder i_frame_builder (
    .clk(clk), .rstN(rstN), .modeAligned(modeAligned), .evId(evId),
    .evMask(evMask), .evTime(evTime), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inBankName(inBankName), .inBankType(inBankType),
    .inBankStart(inBankStart), .inBankEnd(inBankEnd), .inEventEnd(inEventEnd),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .errOverflow(errOverflow)
  );

  int total = 0;
  int bad   = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic [31:0] expSerial = 0;
  int  errCnt = 0;
  int  unexpected = 0;
  bit  rdyRandom = 0;
  bit  sawFirst = 0;
  bit  gapSeen = 0;
  bit  busyIn = 0;
  bit  monOn = 0;

  int          nBanks;
  int          bLen  [16];
  logic [31:0] bName [16];
  logic [31:0] bType [16];
  logic [31:0] pay   [128];

  task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  // output side: readiness and acceptance, sampled away from the rising edge
  initial begin
    outReady = 1'b0;
    forever begin
      @(negedge clk);
      outReady = rdyRandom ? 1'($urandom % 2) : 1'b1;
      #1;
      if (monOn) begin
        if (errOverflow) errCnt++;
        if (sawFirst && inReady) busyIn = 1;
        if (!rdyRandom && sawFirst && expQ.size() > 0 && !outValid) gapSeen = 1;
        if (outValid && outReady) begin
          if (expQ.size() == 0) begin
            unexpected++;
            check(0, "R8 unexpected word", outData, 32'h0);
          end else begin
            automatic logic [31:0] e = expQ.pop_front();
            automatic string t = tagQ.pop_front();
            check(outData === e, t, outData, e);
            sawFirst = (expQ.size() != 0);
          end
        end
      end
    end
  end

  task automatic pushExp(logic [31:0] w, string t);
    expQ.push_back(w);
    tagQ.push_back(t);
  endtask

  task automatic buildExp(bit mode);
    int allB = 0;
    int words, tail, off;
    for (int b = 0; b < nBanks; b++) begin
      if (mode) allB += ((12 + 4*bLen[b] + 7) / 8) * 8;
      else      allB += 12 + ((4*bLen[b] + 7) / 8) * 8;
    end
    words = 6 + allB / 4;
    tail  = (8 - words % 8) % 8;
    pushExp({evMask, evId}, "R1 id/mask");
    pushExp(expSerial, "R7 serial");
    pushExp(evTime, "R1 time");
    pushExp(32'(allB + 8), "R1 event size");
    pushExp(32'(allB), "R2 bank total");
    pushExp(mode ? 32'h31 : 32'h11, "R2 R10 flags");
    off = 0;
    for (int b = 0; b < nBanks; b++) begin
      int contrib, padW;
      contrib = mode ? ((12 + 4*bLen[b] + 7) / 8) * 8 : 12 + ((4*bLen[b] + 7) / 8) * 8;
      padW = (contrib - 12 - 4*bLen[b]) / 4;
      pushExp(bName[b], "R3 name");
      pushExp(bType[b], "R3 type");
      pushExp(32'(4*bLen[b]), "R3 length");
      for (int w = 0; w < bLen[b]; w++) pushExp(pay[off + w], "R3 payload");
      for (int p = 0; p < padW; p++) pushExp(32'h0, mode ? "R5 bank pad" : "R4 bank pad");
      off += bLen[b];
    end
    for (int p = 0; p < tail; p++) pushExp(32'h0, "R6 tail pad");
    expSerial++;
  endtask

  task automatic sendEvent(bit mode, bit flip);
    int off = 0;
    bit first = 1;
    for (int b = 0; b < nBanks; b++) begin
      for (int w = 0; w < bLen[b]; w++) begin
        @(negedge clk);
        inValid     = 1'b1;
        inData      = pay[off + w];
        inBankName  = (w == 0) ? bName[b] : 32'hDEAD_0000;
        inBankType  = (w == 0) ? bType[b] : 32'hBEEF;
        inBankStart = (w == 0);
        inBankEnd   = (w == bLen[b] - 1);
        inEventEnd  = (w == bLen[b] - 1) && (b == nBanks - 1);
        if (!first && flip) begin
          modeAligned = ~mode;
          evId = ~evId; evMask = ~evMask; evTime = ~evTime;
        end else modeAligned = mode;
        while (!inReady) @(negedge clk);
        @(posedge clk);
        if (first && flip) begin
          evId = ~evId; evMask = ~evMask; evTime = ~evTime;
        end
        if (flip) begin evId = ~evId; evMask = ~evMask; evTime = ~evTime; end
        first = 0;
      end
      off += bLen[b];
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic fillBanks(int nb, int len0, int lenRest);
    int off = 0;
    nBanks = nb;
    for (int b = 0; b < nb; b++) begin
      bLen[b]  = (b == 0) ? len0 : lenRest;
      bName[b] = 32'h4B4E_4130 + 32'(b);
      bType[b] = 32'd6;
      for (int w = 0; w < bLen[b]; w++) pay[off + w] = $urandom;
      off += bLen[b];
    end
  endtask

  task automatic runEvent(bit mode, bit flip, bit expectDrop);
    int e0 = errCnt;
    int u0 = unexpected;
    evId = 16'($urandom); evMask = 16'($urandom); evTime = $urandom;
    gapSeen = 0; busyIn = 0;
    if (!expectDrop) buildExp(mode);
    sendEvent(mode, flip);
    if (expectDrop) begin
      repeat (4) @(negedge clk);
      check(errCnt == e0 + 1, "R8 one error pulse", 32'(errCnt - e0), 32'd1);
      check(unexpected == u0, "R8 no output on drop", 32'(unexpected - u0), 32'd0);
    end else begin
      while (expQ.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      check(errCnt == e0, "R8 no error on good event", 32'(errCnt - e0), 32'd0);
      check(!busyIn, "R9 input stalled during emission", 32'(busyIn), 32'd0);
      if (!rdyRandom) check(!gapSeen, "R9 no gap with ready high", 32'(gapSeen), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; inValid = 1'b0; modeAligned = 1'b0;
    evId = '0; evMask = '0; evTime = '0; inData = '0;
    inBankName = '0; inBankType = '0;
    inBankStart = 1'b0; inBankEnd = 1'b0; inEventEnd = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;
    // R11 reset state
    check(outValid == 1'b0, "R11 outValid after reset", 32'(outValid), 32'd0);
    check(inReady == 1'b1, "R11 inReady after reset", 32'(inReady), 32'd1);
    check(errOverflow == 1'b0, "R11 errOverflow after reset", 32'(errOverflow), 32'd0);
    monOn = 1;

    // R4 legacy: odd length padded, even not
    fillBanks(2, 1, 2);  runEvent(1'b0, 1'b0, 1'b0);
    // R5 corrected: even length padded, odd not
    fillBanks(2, 2, 3);  runEvent(1'b1, 1'b0, 1'b0);
    // two banks of three words, corrected rule
    fillBanks(2, 3, 3);  runEvent(1'b1, 1'b0, 1'b0);
    // R10 mode and event fields change after first beat
    fillBanks(3, 2, 4);  runEvent(1'b1, 1'b1, 1'b0);
    fillBanks(2, 3, 1);  runEvent(1'b0, 1'b1, 1'b0);
    // buffer exactly full: accepted
    fillBanks(1, 64, 1); runEvent(1'b0, 1'b0, 1'b0);
    // R8 payload one word too many
    fillBanks(2, 40, 25); runEvent(1'b0, 1'b0, 1'b1);
    // R8 too many banks
    fillBanks(9, 1, 1);  runEvent(1'b1, 1'b0, 1'b1);
    // max bank count accepted, serial continues (R7)
    fillBanks(8, 1, 2);  runEvent(1'b1, 1'b0, 1'b0);

    // random mix with stalls on the output
    for (int i = 0; i < 30; i++) begin
      rdyRandom = (i % 2 == 0);
      fillBanks(1 + int'($urandom % 4), 1 + int'($urandom % 10), 1 + int'($urandom % 10));
      runEvent(1'($urandom % 2), 1'b0, 1'b0);
    end
    rdyRandom = 0;
    fillBanks(2, 45, 30); runEvent(1'b1, 1'b0, 1'b1);
    fillBanks(4, 5, 6);   runEvent(1'b0, 1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule